// File: doc/BRIEF.md
# Packed pixel format converter

This block converts packed pixel data between fixed-point and byte formats for a media datapath. Each accepted operation takes two 64-bit source words, a 9-bit operation code and a format status word. The status word supplies the left-shift scale used by the three pack modes. The block computes the converted word with combinational logic and registers it. The result appears one cycle after the request, together with a valid pulse.

Three pack modes narrow signed lanes by scaling, shifting and saturating them: 16-bit lanes to bytes, 32-bit lanes to bytes merged into a shifted copy of the first operand, and 32-bit lanes to saturated 16-bit values. Two further modes rearrange bytes. Expand widens bytes into 16-bit fixed-point lanes. Merge interleaves the bytes of two 32-bit words. Results that are only 32 bits wide occupy the low half of the output, and the upper half is zero. An unknown operation code produces a zero result and raises an illegal flag in the same cycle as the valid pulse.

Top module: `pixfmt_conv`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` changes only in the cycle after an accepted request and otherwise holds its value.
- R2: The operation codes are 9'h03b (16-bit pack), 9'h03a (32-bit pack), 9'h03d (fixed pack), 9'h04d (expand) and 9'h04b (merge). For any other code, `result` is zero and `illegal_op` is high in the same cycle as `out_valid`. `illegal_op` is low in every other cycle.
- R3: The scale is read from `fmt_status` starting at bit 3. It is bits [6:3] for the 16-bit pack and bits [7:3] for the 32-bit and fixed packs. No other status bit affects any result, and bit 7 has no effect on the 16-bit pack.
- R4: 16-bit pack. Lane i of `src_b` (bits [16i+15:16i]) is taken as signed, shifted left by the scale and then arithmetically right by 7. The value is placed in result byte i.
- R5: 16-bit pack. Each lane value is clamped to 0..255, and result bits [63:32] are zero.
- R6: 32-bit pack. The result starts from `src_a` shifted left by 8, with result bytes 0 and 4 forced to zero before the lanes are inserted.
- R7: 32-bit pack. Signed 32-bit lane w of `src_b` is shifted left by the scale and then arithmetically right by 23. The value is clamped to 0..255 and written to result bits [32w+7:32w].
- R8: Fixed pack. Signed 32-bit lane w of `src_b` is shifted left by the scale and then arithmetically right by 16. The value is saturated to -32768..32767 and written to result bits [16w+15:16w]. Bits [63:32] are zero.
- R9: Expand. Byte k of `src_b[31:0]` is zero-extended, shifted left by 4 and written to result bits [16k+15:16k].
- R10: Merge. Result byte 2k holds byte k of `src_b[31:0]`, and result byte 2k+1 holds byte k of `src_a[31:0]`.
- R11: While `rst` is high, `out_valid`, `illegal_op` and `result` go to zero at the clock edge.
- R12: Scaled intermediates never wrap. A scale of 31 on a positive 32-bit lane saturates high, and on a negative lane saturates low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands are sampled when high |
| op_code | input | 9 | Operation selector |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| fmt_status | input | 32 | Format status word; the scale field starts at bit 3 |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Registered converted data |
| illegal_op | output | 1 | High with out_valid when the code is not supported |

## Verification
A wrong scale-field slice or clamp bound appears in `result` on the very next valid cycle, but only for lanes whose scaled value crosses a clamp edge or uses the affected status bit. The bench therefore drives lanes at and beyond each saturation limit, and status words with the neighbouring bits set. Corrupted output state, such as a result register that updates without a request or an illegal flag that does not clear, shows up one cycle later. The bench compares every cycle, including idle ones, against a behavioural model.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;
  localparam int WORD_W  = 64;
  localparam int HALF_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int OP_W    = 9;

  typedef enum logic [OP_W-1:0] {
    OP_PACK16  = 9'h03b,
    OP_PACK32  = 9'h03a,
    OP_PACKFIX = 9'h03d,
    OP_EXPAND  = 9'h04d,
    OP_MERGE   = 9'h04b
  } fmt_op_e;
endpackage

// File: rtl/pixfmt_sat_lane.sv
// One lane: sign-extend, scale left, shift right, clamp to the output range.
module pixfmt_sat_lane #(
  parameter int IN_W       = 16,
  parameter int SCL_W      = 4,
  parameter int RSHIFT     = 7,
  parameter int OUT_W      = 8,
  parameter bit SIGNED_OUT = 1'b0
) (
  input  logic [IN_W-1:0]  lane_in,
  input  logic [SCL_W-1:0] scale,
  output logic [OUT_W-1:0] lane_out
);
  localparam int EXT_W = 64;
  localparam logic signed [EXT_W-1:0] HI_LIM = SIGNED_OUT ?
      ((64'sd1 <<< (OUT_W-1)) - 64'sd1) : ((64'sd1 <<< OUT_W) - 64'sd1);
  localparam logic signed [EXT_W-1:0] LO_LIM = SIGNED_OUT ?
      (-(64'sd1 <<< (OUT_W-1))) : 64'sd0;

  logic signed [EXT_W-1:0] ext_v;
  logic signed [EXT_W-1:0] shl_v;
  logic signed [EXT_W-1:0] shr_v;

  always_comb begin
    ext_v = {{(EXT_W-IN_W){lane_in[IN_W-1]}}, lane_in};
    shl_v = ext_v <<< scale;
    shr_v = shl_v >>> RSHIFT;
    if (shr_v > HI_LIM)      lane_out = HI_LIM[OUT_W-1:0];
    else if (shr_v < LO_LIM) lane_out = LO_LIM[OUT_W-1:0];
    else                     lane_out = shr_v[OUT_W-1:0];
  end
endmodule

// File: rtl/pixfmt_pack_unit.sv
// The three saturating pack modes, computed in parallel.
module pixfmt_pack_unit
  import pixfmt_pkg::*;
#(
  parameter int STAT_W    = 32,
  parameter int SCALE_LSB = 3,
  parameter int S16_W     = 4,
  parameter int S32_W     = 5
) (
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  input  logic [STAT_W-1:0] fmt_status,
  output logic [WORD_W-1:0] pk16_res,
  output logic [WORD_W-1:0] pk32_res,
  output logic [WORD_W-1:0] pkfix_res
);
  localparam int L16_W    = 16;
  localparam int L32_W    = 32;
  localparam int N16      = WORD_W / L16_W;
  localparam int N32      = WORD_W / L32_W;
  localparam int RSH_P16  = 7;
  localparam int RSH_P32  = 23;
  localparam int RSH_FIX  = 16;
  localparam int FIX_W    = 16;

  logic [S16_W-1:0] scale16;
  logic [S32_W-1:0] scale32;
  logic [BYTE_W-1:0] p16_byte [N16];
  logic [BYTE_W-1:0] p32_byte [N32];
  logic [FIX_W-1:0]  fix_half [N32];

  assign scale16 = fmt_status[SCALE_LSB +: S16_W];
  assign scale32 = fmt_status[SCALE_LSB +: S32_W];

  for (genvar g = 0; g < N16; g++) begin : g_p16
    pixfmt_sat_lane #(
      .IN_W(L16_W), .SCL_W(S16_W), .RSHIFT(RSH_P16),
      .OUT_W(BYTE_W), .SIGNED_OUT(1'b0)
    ) u_lane (
      .lane_in (src_b[g*L16_W +: L16_W]),
      .scale   (scale16),
      .lane_out(p16_byte[g])
    );
  end

  for (genvar g = 0; g < N32; g++) begin : g_p32
    pixfmt_sat_lane #(
      .IN_W(L32_W), .SCL_W(S32_W), .RSHIFT(RSH_P32),
      .OUT_W(BYTE_W), .SIGNED_OUT(1'b0)
    ) u_byte (
      .lane_in (src_b[g*L32_W +: L32_W]),
      .scale   (scale32),
      .lane_out(p32_byte[g])
    );
    pixfmt_sat_lane #(
      .IN_W(L32_W), .SCL_W(S32_W), .RSHIFT(RSH_FIX),
      .OUT_W(FIX_W), .SIGNED_OUT(1'b1)
    ) u_fix (
      .lane_in (src_b[g*L32_W +: L32_W]),
      .scale   (scale32),
      .lane_out(fix_half[g])
    );
  end

  always_comb begin
    pk16_res = '0;
    for (int i = 0; i < N16; i++) pk16_res[i*BYTE_W +: BYTE_W] = p16_byte[i];
  end

  // Shifted first operand; the inserted lane byte replaces the byte that
  // would otherwise carry shifted-in data, so bytes 0 and 4 hold only lanes.
  always_comb begin
    pk32_res = src_a << BYTE_W;
    for (int w = 0; w < N32; w++) pk32_res[w*L32_W +: BYTE_W] = p32_byte[w];
  end

  always_comb begin
    pkfix_res = '0;
    for (int w = 0; w < N32; w++) pkfix_res[w*FIX_W +: FIX_W] = fix_half[w];
  end
endmodule

// File: rtl/pixfmt_shuffle_unit.sv
// Byte expand and byte interleave merge.
module pixfmt_shuffle_unit
  import pixfmt_pkg::*;
#(
  parameter int EXP_LSH = 4
) (
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  output logic [WORD_W-1:0] exp_res,
  output logic [WORD_W-1:0] mrg_res
);
  localparam int NB     = HALF_W / BYTE_W;
  localparam int SLOT_W = 2 * BYTE_W;
  localparam int PAD_HI = SLOT_W - BYTE_W - EXP_LSH;

  always_comb begin
    exp_res = '0;
    mrg_res = '0;
    for (int k = 0; k < NB; k++) begin
      exp_res[k*SLOT_W +: SLOT_W] =
          {{PAD_HI{1'b0}}, src_b[k*BYTE_W +: BYTE_W], {EXP_LSH{1'b0}}};
      mrg_res[k*SLOT_W +: BYTE_W]          = src_b[k*BYTE_W +: BYTE_W];
      mrg_res[k*SLOT_W + BYTE_W +: BYTE_W] = src_a[k*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/pixfmt_conv.sv
module pixfmt_conv
  import pixfmt_pkg::*;
#(
  parameter int STAT_W    = 32,
  parameter int SCALE_LSB = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [8:0]        op_code,
  input  logic [63:0]       src_a,
  input  logic [63:0]       src_b,
  input  logic [STAT_W-1:0] fmt_status,
  output logic              out_valid,
  output logic [63:0]       result,
  output logic              illegal_op
);
  logic [WORD_W-1:0] pk16_res, pk32_res, pkfix_res, exp_res, mrg_res;
  logic [WORD_W-1:0] nxt_res;
  logic              nxt_ill;

  pixfmt_pack_unit #(
    .STAT_W(STAT_W), .SCALE_LSB(SCALE_LSB), .S16_W(4), .S32_W(5)
  ) u_pack (
    .src_a     (src_a),
    .src_b     (src_b),
    .fmt_status(fmt_status),
    .pk16_res  (pk16_res),
    .pk32_res  (pk32_res),
    .pkfix_res (pkfix_res)
  );

  pixfmt_shuffle_unit #(.EXP_LSH(4)) u_shuf (
    .src_a  (src_a),
    .src_b  (src_b),
    .exp_res(exp_res),
    .mrg_res(mrg_res)
  );

  always_comb begin
    nxt_ill = 1'b0;
    case (op_code)
      OP_PACK16:  nxt_res = pk16_res;
      OP_PACK32:  nxt_res = pk32_res;
      OP_PACKFIX: nxt_res = pkfix_res;
      OP_EXPAND:  nxt_res = exp_res;
      OP_MERGE:   nxt_res = mrg_res;
      default: begin
        nxt_res = '0;
        nxt_ill = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      illegal_op <= 1'b0;
      result     <= '0;
    end else begin
      out_valid  <= in_valid;
      illegal_op <= in_valid & nxt_ill;
      if (in_valid) result <= nxt_res;
    end
  end
endmodule

// File: rtl/pixfmt_conv_chk.sv
module pixfmt_conv_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [8:0]  op_code,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        illegal_op
);
  // R1
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R1
  a_r1_result_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  // R2
  a_r2_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> (out_valid && result == 64'd0));
  // R5
  a_r5_pack16_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == 9'h03b) |=> (result[63:32] == 32'd0));
  // R8
  a_r8_fix_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == 9'h03d) |=> (result[63:32] == 32'd0));
  // R9
  a_r9_expand_pad: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == 9'h04d) |=> ((result & 64'hF00F_F00F_F00F_F00F) == 64'd0));
  // R11
  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !illegal_op && result == 64'd0));
endmodule

bind pixfmt_conv pixfmt_conv_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_code   (op_code),
  .out_valid (out_valid),
  .result    (result),
  .illegal_op(illegal_op)
);

// File: tb/pixfmt_conv_tb_top.sv
`timescale 1ns/1ps
module pixfmt_conv_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [8:0]  op_code;
  logic [63:0] src_a, src_b;
  logic [31:0] fmt_status;
  logic        out_valid, illegal_op;
  logic [63:0] result;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic        exp_valid = 1'b0;
  logic        exp_ill   = 1'b0;
  logic [63:0] exp_res   = 64'd0;

  always #10 clk = ~clk;

  pixfmt_conv dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .fmt_status(fmt_status),
    .out_valid(out_valid), .result(result), .illegal_op(illegal_op)
  );

  function automatic longint clampv(longint v, longint lo, longint hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Behavioural model: {illegal, data}
  function automatic logic [64:0] model(logic [8:0] op, logic [63:0] a,
                                        logic [63:0] b, logic [31:0] st);
    int s4 = int'(st[6:3]);
    int s5 = int'(st[7:3]);
    longint v;
    logic [63:0] r = 64'd0;
    case (op)
      9'h03b: for (int i = 0; i < 4; i++) begin
        v = longint'(shortint'(b[16*i +: 16]));
        v = (v <<< s4) >>> 7;
        v = clampv(v, 0, 255);
        r[8*i +: 8] = v[7:0];
      end
      9'h03a: begin
        r = a << 8;
        r[7:0] = 8'd0;
        r[39:32] = 8'd0;
        for (int w = 0; w < 2; w++) begin
          v = longint'(int'(b[32*w +: 32]));
          v = (v <<< s5) >>> 23;
          v = clampv(v, 0, 255);
          r[32*w +: 8] = v[7:0];
        end
      end
      9'h03d: for (int w = 0; w < 2; w++) begin
        v = longint'(int'(b[32*w +: 32]));
        v = (v <<< s5) >>> 16;
        v = clampv(v, -32768, 32767);
        r[16*w +: 16] = v[15:0];
      end
      9'h04d: for (int k = 0; k < 4; k++)
        r[16*k +: 16] = {4'd0, b[8*k +: 8], 4'd0};
      9'h04b: for (int k = 0; k < 4; k++) begin
        r[16*k +: 8]     = b[8*k +: 8];
        r[16*k + 8 +: 8] = a[8*k +: 8];
      end
      default: return {1'b1, 64'd0};
    endcase
    return {1'b0, r};
  endfunction

  task automatic check(string tag);
    n_tests++;
    if (out_valid !== exp_valid || illegal_op !== exp_ill || result !== exp_res) begin
      n_fail++;
      $display("FAIL %s: actual v=%0b ill=%0b res=%h expected v=%0b ill=%0b res=%h",
               tag, out_valid, illegal_op, result, exp_valid, exp_ill, exp_res);
    end
  endtask

  // One cycle: drive at negedge, update model at posedge, compare at next negedge.
  task automatic cyc(logic v, logic [8:0] op, logic [63:0] a, logic [63:0] b,
                     logic [31:0] st, string tag);
    logic [64:0] m;
    in_valid = v; op_code = op; src_a = a; src_b = b; fmt_status = st;
    @(posedge clk);
    exp_valid = v;
    if (v) begin
      m = model(op, a, b, st);
      exp_ill = m[64];
      exp_res = m[63:0];
    end else begin
      exp_ill = 1'b0;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [8:0] ops [7];
    rst = 1'b1; in_valid = 1'b0; op_code = '0; src_a = '0; src_b = '0; fmt_status = '0;
    repeat (3) @(negedge clk);
    check("R11 reset state");
    rst = 1'b0;

    // R4 R5: 16-bit pack, scale 0, lanes across clamp edges
    cyc(1, 9'h03b, 64'h0, 64'h0100_FF00_0080_7FFF, 32'h0, "R4 pack16 scale0");
    cyc(1, 9'h03b, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0001_00FF_0040, 32'h0000_0010, "R5 pack16 clamp scale2");
    // R3: bit 7 set and low bits set, scale16 stays 1
    cyc(1, 9'h03b, 64'h0, 64'h0081_00C0_0100_0020, 32'hFFFF_FF8F, "R3 pack16 ignores bit7");
    cyc(1, 9'h03a, 64'h1122_3344_5566_7788, 64'h7FFF_FFFF_FFFF_FFFF, 32'hFFFF_FF07, "R3 pack32 scale from bits7:3");
    // R6 R7
    cyc(1, 9'h03a, 64'hA1B2_C3D4_E5F6_0718, 64'h0080_0000_0040_0000, 32'h0, "R6 pack32 base shift");
    cyc(1, 9'h03a, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0100_8000_0000, 32'h0000_0078, "R7 pack32 scale15");
    // R12: scale 31
    cyc(1, 9'h03a, 64'h0, 64'h0000_0001_FFFF_FFFF, 32'h0000_00F8, "R12 pack32 scale31");
    cyc(1, 9'h03d, 64'h0, 64'h7FFF_FFFF_8000_0000, 32'h0000_00F8, "R12 fixpack scale31");
    // R8
    cyc(1, 9'h03d, 64'h0, 64'h0001_2345_FFFE_0000, 32'h0, "R8 fixpack scale0");
    cyc(1, 9'h03d, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_4000_FFFF_C000, 32'h0000_0008, "R8 fixpack scale1");
    // R9 R10
    cyc(1, 9'h04d, 64'hDEAD_BEEF_0000_0000, 64'hFFFF_FFFF_FF80_01A5, 32'h0, "R9 expand");
    cyc(1, 9'h04b, 64'hFFFF_FFFF_0123_4567, 64'h0000_0000_89AB_CDEF, 32'h0, "R10 merge");
    // R1: idle cycles hold result
    cyc(0, 9'h03b, 64'h5555, 64'h7777, 32'hFF, "R1 hold idle");
    cyc(0, 9'h1FF, 64'h0, 64'h0, 32'h0, "R1 hold idle");
    // R2: illegal codes, then recovery
    cyc(1, 9'h03c, 64'h1234, 64'h5678, 32'h0, "R2 illegal 03c");
    cyc(1, 9'h1FF, 64'h1234, 64'h5678, 32'h0, "R2 illegal 1ff");
    cyc(0, 9'h000, 64'h0, 64'h0, 32'h0, "R2 illegal clears");
    cyc(1, 9'h04b, 64'h0000_0000_0A0B_0C0D, 64'h0000_0000_0102_0304, 32'h0, "R2 legal after illegal");

    ops = '{9'h03b, 9'h03a, 9'h03d, 9'h04d, 9'h04b, 9'h03e, 9'h04c};
    for (int n = 0; n < 400; n++) begin
      cyc(($urandom % 4) != 0, ops[$urandom % 7],
          {$urandom, $urandom}, {$urandom, $urandom}, $urandom, "R2 random mix");
    end

    // R11: reset mid-run clears outputs
    in_valid = 1'b1; rst = 1'b1;
    @(posedge clk);
    exp_valid = 1'b0; exp_ill = 1'b0; exp_res = 64'd0;
    @(negedge clk);
    check("R11 reset mid-run");
    rst = 1'b0;
    cyc(0, 9'h0, 64'h0, 64'h0, 32'h0, "R11 idle after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule